// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Occupancy Flags

A first-in/first-out buffer of 64 words of 5 bits. The writer and the reader each move data with a strobe pulse and a ready line, not with a level enable. The writer raises `shiftIn` while `inReady` is high. The word on `dataIn` is taken at that moment, and `inReady` drops. When the writer lowers `shiftIn`, the write is committed. The reader sees the oldest word on `dataOut` whenever `outReady` is high. It takes that word with a `shiftOut` pulse: the rising edge withdraws `outReady`, and the falling edge retires the word. One cycle later the next word, if there is one, is presented and `outReady` returns high.

Both strobes are synchronous to `clk`. Each is registered once, and its edges are found by comparing the live value with the registered one. An occupancy count drives two flags. `halfFull` reports that at least half the storage is used. `nearEdge` is a single flag that is raised both when the buffer is almost empty and when it is almost full. An active-low `outEnN` releases the data bus, and the active-low `rstN` empties the buffer.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low and after its release, `outReady` is 0, `inReady` is 1, the driven `dataOut` is all zeros, `halfFull` is 0 and `nearEdge` is 1.
- R2: A clock sample with `shiftIn` high and `inReady` high captures `dataIn` and clears `inReady` on that edge. At the first sample with `shiftIn` low, the write commits and `inReady` returns to 1, unless the buffer now holds 64 words.
- R3: With 64 words stored, `inReady` stays 0, and a `shiftIn` pulse that starts and ends while `inReady` is 0 stores nothing.
- R4: If `shiftIn` is held high while the buffer is full, the held word is stored once a read frees a slot. That word is the last one read out.
- R5: A word written into an empty buffer appears on `dataOut` with `outReady` high one cycle after its write commits.
- R6: A rising `shiftOut` sampled while `outReady` is 1 clears `outReady` at that edge. After the falling `shiftOut` is sampled, the next stored word appears with `outReady` high one cycle later. Words leave in the order they were written.
- R7: A `shiftOut` pulse given while `outReady` is 0 has no effect on the contents or on `dataOut`.
- R8: When the last word has been read, `outReady` stays 0 and `dataOut` keeps showing that last word.
- R9: `halfFull` is 1 exactly when 32 or more words are stored.
- R10: `nearEdge` is 1 exactly when 8 or fewer, or 56 or more, words are stored.
- R11: With `outEnN` high, `dataOut` is high impedance. With `outEnN` low, `dataOut` drives the head word.
- R12: A write and a read that commit in the same cycle leave the occupancy unchanged, and both words keep their order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low master reset, empties the buffer |
| shiftIn | input | 1 | Write strobe; rise captures, fall commits |
| dataIn | input | 5 | Word to be written |
| inReady | output | 1 | High when a write may start |
| shiftOut | input | 1 | Read strobe; rise takes the head, fall retires it |
| dataOut | output | 5 | Head word, high impedance when disabled |
| outReady | output | 1 | High when `dataOut` holds an unread word |
| outEnN | input | 1 | Active-low output enable for `dataOut` |
| halfFull | output | 1 | 32 or more words stored |
| nearEdge | output | 1 | 8 or fewer, or 56 or more, words stored |

## Verification
Single writes into an empty buffer measure the fall-through latency and the ready timing cycle by cycle. A fill to 64 words followed by a full drain checks order and every flag value at each occupancy, so an off-by-one threshold on either side is caught. Pulses given against a low ready line, on a full buffer and on an empty one, separate a handshake that ignores them from one that corrupts the count. A strobe held high through a full condition, and a write and read that commit together, each test a path that the one-at-a-time patterns never reach.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // Strobes passed from control to datapath, one cycle of effect each
  typedef struct packed {
    logic memWr;     // store dataIn at the write pointer
    logic wrAdv;     // commit a write: advance the write pointer
    logic rdAdv;     // retire the head: advance the read pointer
    logic headLoad;  // copy the word at the read pointer to the output register
  } fifo_strobe_t;

endpackage

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  output logic             inReady,
  output logic             outReady,
  output logic [CNT_W-1:0] occ,
  output fifo_strobe_t     strb
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic siQ, soQ;
  logic wrPend, rdPend;
  logic wrStart, wrDone, rdStart, rdDone, headLoad;
  logic wrPendNext, rdPendNext;
  logic [CNT_W-1:0] occNext;

  // Registered copies of the strobes for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siQ <= 1'b0;
      soQ <= 1'b0;
    end else begin
      siQ <= shiftIn;
      soQ <= shiftOut;
    end
  end

  // A write starts on any sample with the strobe high and space offered;
  // a strobe held high through a full spell thus loads once space returns.
  assign wrStart  = inReady & shiftIn;
  assign wrDone   = wrPend & siQ & ~shiftIn;
  // A read needs a fresh rising edge while the head is offered.
  assign rdStart  = outReady & shiftOut & ~soQ;
  assign rdDone   = rdPend & soQ & ~shiftOut;
  assign headLoad = ~outReady & ~rdPend & (occ != '0);

  assign wrPendNext = wrStart | (wrPend & ~wrDone);
  assign rdPendNext = rdStart | (rdPend & ~rdDone);

  always_comb begin
    occNext = occ;
    if (wrDone && !rdDone)      occNext = occ + 1'b1;
    else if (rdDone && !wrDone) occNext = occ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPend   <= 1'b0;
      rdPend   <= 1'b0;
      occ      <= '0;
      inReady  <= 1'b1;
      outReady <= 1'b0;
    end else begin
      wrPend  <= wrPendNext;
      rdPend  <= rdPendNext;
      occ     <= occNext;
      inReady <= ~wrPendNext & (occNext != FULL_CNT);
      if (rdStart)       outReady <= 1'b0;
      else if (headLoad) outReady <= 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.memWr    = wrStart;
    strb.wrAdv    = wrDone;
    strb.rdAdv    = rdDone;
    strb.headLoad = headLoad;
  end

endmodule

// File: rtl/strobe_fifo_dpath.sv
module strobe_fifo_dpath
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 5,
  parameter int ADDR_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  fifo_strobe_t     strb,
  output logic [WIDTH-1:0] headWord
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      headWord <= '0;
    end else begin
      if (strb.wrAdv) wrPtr <= (wrPtr == LAST_ADDR) ? '0 : wrPtr + 1'b1;
      if (strb.rdAdv) rdPtr <= (rdPtr == LAST_ADDR) ? '0 : rdPtr + 1'b1;
      if (strb.headLoad) headWord <= mem[rdPtr];
    end
  end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             outReady,
  input  logic             outEnN,
  output logic             halfFull,
  output logic             nearEdge
);

  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int HALF_MARK = DEPTH / 2;
  localparam int LOW_MARK  = DEPTH / 8;
  localparam int HIGH_MARK = DEPTH - DEPTH / 8;

  fifo_strobe_t     strb;
  logic [CNT_W-1:0] occ;
  logic [WIDTH-1:0] headWord;

  strobe_fifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrlU (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .inReady(inReady), .outReady(outReady), .occ(occ), .strb(strb)
  );

  strobe_fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) dpathU (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strb(strb), .headWord(headWord)
  );

  assign halfFull = (occ >= CNT_W'(HALF_MARK));
  assign nearEdge = (occ <= CNT_W'(LOW_MARK)) || (occ >= CNT_W'(HIGH_MARK));
  assign dataOut  = outEnN ? {WIDTH{1'bz}} : headWord;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 5,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             shiftIn,
  input logic             shiftOut,
  input logic             inReady,
  input logic             outReady,
  input logic             halfFull,
  input logic [CNT_W-1:0] occ,
  input logic [WIDTH-1:0] headWord
);

  // R2
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && shiftIn) |=> !inReady);

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == CNT_W'(DEPTH)) |-> !inReady);

  // R6
  rd_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && $rose(shiftOut)) |=> !outReady);

  // R7
  empty_nohead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !outReady);

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outReady && !$past(outReady)) |-> $stable(headWord));

  // R9
  hf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfFull) |-> !$past(inReady));

  // R12
  occ_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ + 1'b1 == $past(occ)));

endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) chkU (
  .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
  .inReady(inReady), .outReady(outReady), .halfFull(halfFull),
  .occ(occ), .headWord(headWord)
);

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       shiftIn, shiftOut, outEnN;
  logic [4:0] dataIn;
  logic       inReady, outReady, halfFull, nearEdge;
  tri1  [4:0] busQ;

  int runs = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [4:0] model[$];

  always #4 clk = ~clk;

  strobe_fifo dut_i (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .dataOut(busQ),
    .outReady(outReady), .outEnN(outEnN), .halfFull(halfFull),
    .nearEdge(nearEdge)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pushWord(input logic [4:0] w);
    dataIn  = w;
    shiftIn = 1'b1;
    @(negedge clk);
    shiftIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic popWord();
    shiftOut = 1'b1;
    @(negedge clk);
    shiftOut = 1'b0;
    idle(2);
  endtask

  task automatic checkFlags(input string tag);
    int n = model.size();
    check(halfFull == (n >= 32), {tag, " R9 halfFull"}, halfFull, (n >= 32));
    check(nearEdge == (n <= 8 || n >= 56), {tag, " R10 nearEdge"}, nearEdge, (n <= 8 || n >= 56));
  endtask

  task automatic drainAll(input string tag, input bit flags);
    logic [4:0] exp;
    idle(1);
    while (model.size() > 0) begin
      exp = model.pop_front();
      check(outReady === 1'b1, {tag, " R6 outReady"}, outReady, 1);
      check(busQ === exp, {tag, " R6 order"}, busQ, exp);
      popWord();
      if (flags) checkFlags(tag);
    end
    check(outReady === 1'b0, {tag, " R8 empty outReady"}, outReady, 0);
  endtask

  task automatic t_reset();
    rstN = 1'b0; shiftIn = 1'b0; shiftOut = 1'b0; outEnN = 1'b0; dataIn = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    check(outReady === 1'b0, "R1 outReady", outReady, 0);
    check(inReady === 1'b1, "R1 inReady", inReady, 1);
    check(busQ === 5'h00, "R1 dataOut", busQ, 0);
    check(halfFull === 1'b0, "R1 halfFull", halfFull, 0);
    check(nearEdge === 1'b1, "R1 nearEdge", nearEdge, 1);
  endtask

  task automatic t_fallthrough();
    dataIn = 5'h15; shiftIn = 1'b1;
    @(negedge clk);
    check(inReady === 1'b0, "R2 inReady drops", inReady, 0);
    shiftIn = 1'b0;
    @(negedge clk);
    check(inReady === 1'b1, "R2 inReady returns", inReady, 1);
    check(outReady === 1'b0, "R5 not yet out", outReady, 0);
    @(negedge clk);
    check(outReady === 1'b1, "R5 outReady", outReady, 1);
    check(busQ === 5'h15, "R5 head", busQ, 5'h15);
    model.push_back(5'h15);
  endtask

  task automatic t_readLast();
    pushWord(5'h0B); model.push_back(5'h0B);
    pushWord(5'h0C); model.push_back(5'h0C);
    void'(model.pop_front());
    shiftOut = 1'b1;
    @(negedge clk);
    check(outReady === 1'b0, "R6 outReady drops", outReady, 0);
    shiftOut = 1'b0;
    idle(2);
    check(outReady === 1'b1 && busQ === 5'h0B, "R6 next head", busQ, 5'h0B);
    drainAll("readLast", 1'b0);
    check(busQ === 5'h0C, "R8 last word kept", busQ, 5'h0C);
    idle(3);
    check(busQ === 5'h0C && outReady === 1'b0, "R8 last word still", busQ, 5'h0C);
  endtask

  task automatic t_ignoredRead();
    popWord();
    check(outReady === 1'b0, "R7 outReady stays", outReady, 0);
    check(busQ === 5'h0C, "R7 dataOut untouched", busQ, 5'h0C);
    pushWord(5'h11);
    idle(1);
    check(outReady === 1'b1 && busQ === 5'h11, "R7 next word intact", busQ, 5'h11);
    popWord();
    check(outReady === 1'b0, "R7 count intact", outReady, 0);
  endtask

  task automatic t_fullHeld();
    for (int k = 0; k < 64; k++) begin
      logic [4:0] w = 5'((k * 7 + 3) & 31);
      pushWord(w);
      model.push_back(w);
      checkFlags("fill");
    end
    check(inReady === 1'b0, "R3 full inReady", inReady, 0);
    pushWord(5'h00);
    check(inReady === 1'b0, "R3 ignored write", inReady, 0);
    dataIn = 5'h1F; shiftIn = 1'b1;
    idle(1);
    check(busQ === model[0], "R4 head before", busQ, model[0]);
    void'(model.pop_front());
    popWord();
    check(inReady === 1'b0, "R4 held write taken", inReady, 0);
    shiftIn = 1'b0;
    idle(1);
    model.push_back(5'h1F);
    check(inReady === 1'b0, "R4 full again", inReady, 0);
    checkFlags("R4 held");
    drainAll("R3 R4 drain", 1'b1);
  endtask

  task automatic t_simul();
    for (int k = 0; k < 9; k++) begin
      pushWord(5'(k + 2));
      model.push_back(5'(k + 2));
    end
    idle(1);
    dataIn = 5'h1A; shiftIn = 1'b1; shiftOut = 1'b1;
    @(negedge clk);
    shiftIn = 1'b0; shiftOut = 1'b0;
    @(negedge clk);
    void'(model.pop_front());
    model.push_back(5'h1A);
    check(nearEdge === 1'b0, "R12 count kept at 9", nearEdge, 0);
    drainAll("R12 drain", 1'b0);
  endtask

  task automatic t_outEnable();
    pushWord(5'h0A);
    idle(1);
    outEnN = 1'b1;
    #1;
    check(busQ === 5'h1F, "R11 released bus", busQ, 5'h1F);
    outEnN = 1'b0;
    #1;
    check(busQ === 5'h0A, "R11 driven bus", busQ, 5'h0A);
    popWord();
  endtask

  initial begin
    t_reset();
    t_fallthrough();
    t_readLast();
    t_ignoredRead();
    t_fullHeld();
    t_simul();
    t_outEnable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

endmodule